// File: doc/BRIEF.md
# Sequential and Stride Prefetcher

This block sits beside a cache and watches the stream of demand block addresses it receives. From that stream it predicts a block that will probably be wanted soon and offers it on a prefetch request port with a valid/ready handshake. The prediction mode is chosen per access. In next-block mode it asks for the block that follows the one just accessed. In stride mode it uses a distance learned from the spacing between successive demand addresses, but only once that distance has repeated.

Prefetch requests are hints. The demand side has no ready signal and is never held back. Address arithmetic wraps modulo the address width and never reports an error. A request that is not taken is replaced by a newer one rather than queued. The block limits how much bandwidth prefetching can use in two ways. It waits a fixed number of cycles after each accepted request before offering another. It also refuses to offer the block it handed out last.

Top module: `pf_prefetch`

## Requirements
- R1: While reset is asserted and in the cycle after it is released, pf_valid_o is 0. Reset also clears the learned distance and the record of the last accepted request.
- R2: When mode_i = 0 and a demand address A is sampled with dmd_valid_i = 1, the candidate is (A + 1) mod 2^AW. If it is loaded, it appears on pf_addr_o with pf_valid_o = 1 after that same clock edge. An address of all ones yields 0.
- R3: The delta of a demand access is (A - previous demand address) mod 2^AW. When mode_i = 1, the distance is trusted only if the delta equals the delta of the previous demand access. The candidate is then (A + delta) mod 2^AW.
- R4: When mode_i = 1, an access whose delta differs from the previous delta gives no candidate. The new delta must repeat on the following access before a stride request is made.
- R5: A delta of zero never produces a stride-mode candidate.
- R6: A candidate equal to the last address accepted on the prefetch port (pf_valid_o and pf_ready_i both 1) is dropped.
- R7: After a request is accepted, pf_valid_o stays 0 for GAP cycles, and candidates arising in that window are discarded. A candidate is also not loaded in the cycle of an acceptance.
- R8: While pf_valid_o = 1 and pf_ready_i = 0, the request stays valid. Its address changes only when a newer candidate replaces it. Nothing is queued.
- R9: The delta history is updated by every demand access, whatever the mode. The first access after reset has no delta.
- R10: After an acceptance, pf_valid_o falls on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dmd_valid_i | input | 1 | Demand access strobe |
| dmd_addr_i | input | AW | Demand block address |
| mode_i | input | 1 | 0 = next block, 1 = stride |
| pf_valid_o | output | 1 | Prefetch request valid |
| pf_addr_o | output | AW | Prefetch block address |
| pf_ready_i | input | 1 | Prefetch request accepted |

## Verification
The hardest states to reach are the ones where several rules apply in the same cycle. Examples are a confirmed stride whose target equals the block just accepted, and a newer candidate arriving while the port is stalled and the rate window has only just closed. The stimulus builds stride runs with deliberate breaks and zero deltas. It toggles mode partway through a run and holds the ready input low across several demand accesses. It repeats addresses so that a candidate equals the last accepted block. A behavioural model predicts the port on every clock.

// File: rtl/pf_pkg.sv
package pf_pkg;
  typedef enum logic {
    PF_NEXT   = 1'b0,
    PF_STRIDE = 1'b1
  } pf_mode_e;
endpackage

// File: rtl/pf_stride_track.sv
module pf_stride_track #(
  parameter int AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          dmd_valid_i,
  input  logic [AW-1:0] dmd_addr_i,
  output logic [AW-1:0] delta_o,
  output logic          trust_o
);
  logic [AW-1:0] last_addr_q, prev_delta_q;
  logic          last_vld_q, delta_vld_q;

  assign delta_o = dmd_addr_i - last_addr_q;
  // confirmed: same nonzero delta on two consecutive accesses
  assign trust_o = last_vld_q && delta_vld_q && (delta_o == prev_delta_q)
                   && (delta_o != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_addr_q  <= '0;
      prev_delta_q <= '0;
      last_vld_q   <= 1'b0;
      delta_vld_q  <= 1'b0;
    end else if (dmd_valid_i) begin
      last_addr_q <= dmd_addr_i;
      last_vld_q  <= 1'b1;
      if (last_vld_q) begin
        prev_delta_q <= delta_o;
        delta_vld_q  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pf_candidate.sv
module pf_candidate
  import pf_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          dmd_valid_i,
  input  logic [AW-1:0] dmd_addr_i,
  input  pf_mode_e      mode_i,
  input  logic [AW-1:0] delta_i,
  input  logic          trust_i,
  output logic          cand_vld_o,
  output logic [AW-1:0] cand_addr_o
);
  always_comb begin
    cand_vld_o  = 1'b0;
    cand_addr_o = dmd_addr_i + AW'(1);
    if (dmd_valid_i) begin
      unique case (mode_i)
        PF_NEXT:   cand_vld_o = 1'b1;
        PF_STRIDE: begin
          cand_vld_o  = trust_i;
          cand_addr_o = dmd_addr_i + delta_i;
        end
        default:   cand_vld_o = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/pf_issue.sv
module pf_issue #(
  parameter int AW  = 16,
  parameter int GAP = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cand_vld_i,
  input  logic [AW-1:0] cand_addr_i,
  input  logic          pf_ready_i,
  output logic          pf_valid_o,
  output logic [AW-1:0] pf_addr_o
);
  localparam int CW = $clog2(GAP + 2);

  logic [CW-1:0] gap_q;
  logic [AW-1:0] acc_addr_q;
  logic          acc_vld_q;
  logic          fire, dup, load;

  assign fire = pf_valid_o && pf_ready_i;
  assign dup  = acc_vld_q && (cand_addr_i == acc_addr_q);
  assign load = cand_vld_i && !dup && (gap_q == '0) && !fire;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q      <= '0;
      acc_addr_q <= '0;
      acc_vld_q  <= 1'b0;
    end else if (fire) begin
      gap_q      <= CW'(GAP);
      acc_addr_q <= pf_addr_o;
      acc_vld_q  <= 1'b1;
    end else if (gap_q != '0) begin
      gap_q <= gap_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pf_valid_o <= 1'b0;
      pf_addr_o  <= '0;
    end else if (load) begin
      pf_valid_o <= 1'b1;
      pf_addr_o  <= cand_addr_i;
    end else if (fire) begin
      pf_valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/pf_prefetch.sv
module pf_prefetch
  import pf_pkg::*;
#(
  parameter int AW  = 16,
  parameter int GAP = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          dmd_valid_i,
  input  logic [AW-1:0] dmd_addr_i,
  input  logic          mode_i,
  output logic          pf_valid_o,
  output logic [AW-1:0] pf_addr_o,
  input  logic          pf_ready_i
);
  logic [AW-1:0] delta, cand_addr;
  logic          trust, cand_vld;

  pf_stride_track #(.AW(AW)) u_track (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .dmd_valid_i (dmd_valid_i),
    .dmd_addr_i  (dmd_addr_i),
    .delta_o     (delta),
    .trust_o     (trust)
  );

  pf_candidate #(.AW(AW)) u_cand (
    .dmd_valid_i (dmd_valid_i),
    .dmd_addr_i  (dmd_addr_i),
    .mode_i      (pf_mode_e'(mode_i)),
    .delta_i     (delta),
    .trust_i     (trust),
    .cand_vld_o  (cand_vld),
    .cand_addr_o (cand_addr)
  );

  pf_issue #(.AW(AW), .GAP(GAP)) u_issue (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cand_vld_i  (cand_vld),
    .cand_addr_i (cand_addr),
    .pf_ready_i  (pf_ready_i),
    .pf_valid_o  (pf_valid_o),
    .pf_addr_o   (pf_addr_o)
  );
endmodule

// File: rtl/pf_prefetch_chk.sv
module pf_prefetch_chk #(
  parameter int AW  = 16,
  parameter int GAP = 2
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          dmd_valid_i,
  input logic [AW-1:0] dmd_addr_i,
  input logic          mode_i,
  input logic          pf_valid_o,
  input logic [AW-1:0] pf_addr_o,
  input logic          pf_ready_i
);
  localparam int CW = $clog2(GAP + 2);

  logic          fire;
  logic [CW-1:0] win_q;
  logic [AW-1:0] last_fire_q, nxt_addr;
  logic          last_fire_vld_q;

  assign fire     = pf_valid_o && pf_ready_i;
  assign nxt_addr = dmd_addr_i + AW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q           <= '0;
      last_fire_q     <= '0;
      last_fire_vld_q <= 1'b0;
    end else if (fire) begin
      win_q           <= CW'(GAP);
      last_fire_q     <= pf_addr_o;
      last_fire_vld_q <= 1'b1;
    end else if (win_q != '0) begin
      win_q <= win_q - 1'b1;
    end
  end

  AST_QUIET_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_q != '0) |-> !pf_valid_o); // R7

  AST_HOLD_STALLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pf_valid_o && !pf_ready_i) |=> pf_valid_o); // R8

  AST_NO_REPEAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && last_fire_vld_q) |-> (pf_addr_o != last_fire_q)); // R6

  AST_SEQ_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dmd_valid_i && !mode_i && !pf_valid_o && win_q == '0
     && !(last_fire_vld_q && nxt_addr == last_fire_q))
    |=> (pf_valid_o && pf_addr_o == $past(nxt_addr))); // R2

  AST_NO_ZERO_STRIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(pf_valid_o) && $past(mode_i)) |-> (pf_addr_o != $past(dmd_addr_i))); // R5

  AST_DROP_AFTER_FIRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |=> !pf_valid_o); // R10
endmodule

bind pf_prefetch pf_prefetch_chk #(.AW(AW), .GAP(GAP)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .dmd_valid_i (dmd_valid_i),
  .dmd_addr_i  (dmd_addr_i),
  .mode_i      (mode_i),
  .pf_valid_o  (pf_valid_o),
  .pf_addr_o   (pf_addr_o),
  .pf_ready_i  (pf_ready_i)
);

// File: tb/sim_pf_prefetch.sv
`timescale 1ns/1ps
module sim_pf_prefetch;
  localparam int AW  = 16;
  localparam int GAP = 2;
  localparam int M   = (1 << AW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          dmd_valid = 1'b0;
  logic [AW-1:0] dmd_addr = '0;
  logic          mode = 1'b0;
  logic          pf_valid;
  logic [AW-1:0] pf_addr;
  logic          pf_ready = 1'b0;

  always #2.5 clk = ~clk;

  pf_prefetch #(.AW(AW), .GAP(GAP)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .dmd_valid_i(dmd_valid), .dmd_addr_i(dmd_addr),
    .mode_i(mode), .pf_valid_o(pf_valid), .pf_addr_o(pf_addr), .pf_ready_i(pf_ready)
  );

  int    n_chk = 0, n_bad = 0, cyc = 0;
  string tag = "R1";

  // behavioural reference
  int m_last, m_delta, m_acc, m_addr, m_cnt;
  bit m_last_v, m_dv, m_acc_v, m_valid;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_last = 0; m_delta = 0; m_acc = 0; m_addr = 0; m_cnt = 0;
      m_last_v = 0; m_dv = 0; m_acc_v = 0; m_valid = 0;
    end else begin
      int d, cand;
      bit cv, fire, ld;
      cv = 0; cand = 0; d = 0;
      fire = m_valid && pf_ready;
      if (dmd_valid) begin
        d = (int'(dmd_addr) - m_last) & M;
        if (!mode) begin
          cand = (int'(dmd_addr) + 1) & M; cv = 1;
        end else if (m_last_v && m_dv && d == m_delta && d != 0) begin
          cand = (int'(dmd_addr) + d) & M; cv = 1;
        end
      end
      ld = cv && !(m_acc_v && cand == m_acc) && m_cnt == 0 && !fire;
      if (fire) begin m_acc = m_addr; m_acc_v = 1; m_cnt = GAP; end
      else if (m_cnt > 0) m_cnt--;
      if (ld) begin m_valid = 1; m_addr = cand; end
      else if (fire) m_valid = 0;
      if (dmd_valid) begin
        if (m_last_v) begin m_delta = d; m_dv = 1; end
        m_last = int'(dmd_addr); m_last_v = 1;
      end
    end
  end

  task automatic compare();
    n_chk++;
    if (pf_valid !== m_valid || (m_valid && int'(pf_addr) != m_addr)) begin
      n_bad++;
      $display("FAIL %s cycle %0d: valid/addr got %0b/%h expected %0b/%h",
               tag, cyc, pf_valid, pf_addr, m_valid, m_addr[AW-1:0]);
    end
  endtask

  task automatic step(bit v, int a, bit md, bit rdy);
    @(negedge clk);
    compare();
    dmd_valid = v; dmd_addr = AW'(a); mode = md; pf_ready = rdy;
  endtask

  task automatic idle(int n, bit rdy);
    for (int i = 0; i < n; i++) step(0, 0, 0, rdy);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    tag = "R1";
    repeat (3) @(negedge clk);
    compare();
    rst_n = 1'b1;
    idle(2, 1);
    tag = "R2";  // next block, including wrap of all ones
    step(1, 100, 0, 1); step(0, 0, 0, 1); step(1, 200, 0, 1);
    idle(4, 1);
    step(1, 'hFFFF, 0, 1); idle(4, 1);
    tag = "R7";  // back-to-back demands inside the quiet window
    for (int i = 0; i < 8; i++) step(1, 300 + i, 0, 1);
    idle(4, 1);
    tag = "R3";  // stride 4 run: 0,4,8,12,16
    for (int i = 0; i < 5; i++) begin step(1, i * 4, 1, 1); idle(3, 1); end
    tag = "R4";  // break the run, then restart with new delta
    step(1, 40, 1, 1); idle(3, 1); step(1, 47, 1, 1); idle(3, 1);
    step(1, 54, 1, 1); idle(3, 1); step(1, 61, 1, 1); idle(3, 1);
    tag = "R5";  // repeated address: zero delta
    for (int i = 0; i < 4; i++) begin step(1, 500, 1, 1); idle(3, 1); end
    tag = "R9";  // learning continues while in next-block mode
    step(1, 1000, 0, 1); idle(3, 1); step(1, 1010, 0, 1); idle(3, 1);
    step(1, 1020, 1, 1); idle(3, 1);
    tag = "R6";  // candidate equal to last accepted block
    step(1, 2000, 0, 1); idle(4, 1); step(1, 2000, 0, 1); idle(4, 1);
    tag = "R8";  // stalled port, overwrites, then drain
    step(1, 3000, 0, 0); step(0, 0, 0, 0); step(0, 0, 0, 0);
    step(1, 3100, 0, 0); step(1, 3200, 0, 0); step(0, 0, 0, 0);
    tag = "R10";
    step(0, 0, 0, 1); idle(4, 1);
    tag = "R3";  // negative stride with wrap
    for (int i = 0; i < 5; i++) begin step(1, (10 - 6 * i) & M, 1, 1); idle(3, 1); end
    tag = "R7";  // mixed stream with intermittent ready
    for (int i = 0; i < 200; i++) step((i % 3) != 2, (i * 5) & M, (i / 20) % 2, (i % 4) != 0);
    tag = "R1";  // reset mid-run
    step(1, 77, 0, 0);
    @(negedge clk); rst_n = 1'b0; dmd_valid = 0;
    @(negedge clk); compare();
    rst_n = 1'b1;
    idle(2, 1);
    step(1, 9, 1, 1); step(1, 9, 1, 1); idle(3, 1);
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule